// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns one starting address into the address sequence of a four-beat burst. A load cycle captures an external address and starts a burst. Each advance cycle after that moves to the next beat. Only the two low address bits change within a burst, and the upper bits stay at the loaded value. A static order input picks one of two sequences. The linear sequence is a wrapping count that starts from the loaded low bits. The interleaved sequence is the loaded low bits XOR the beat number.

A load cycle with the select qualifier low starts nothing and closes any burst in progress. A suspend input freezes all internal state for as long as it is held. The address output is taken directly from registered state, so it shows the new beat in the cycle after the edge that produced it.

Top module: `burst_addr_gen`

## Requirements
- R1: During and after synchronous reset, `addr_out` is 0 and `burst_active` is 0.
- R2: At a clock edge with `suspend`=0, `step`=0 and `sel`=1, the block captures `addr_in` and starts a burst at beat 0. After that edge, `addr_out` equals the captured address and `burst_active` is 1. This also applies when a burst is already running.
- R3: At a clock edge with `step`=1, `addr_in` is ignored. Bits above bit 1 of `addr_out` keep their loaded value for the whole burst.
- R4: With `order_ilv`=0 (linear), bits [1:0] of `addr_out` equal (start + beat) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R5: With `order_ilv`=1 (interleaved), bits [1:0] of `addr_out` equal start XOR beat. For example, a start of 1 gives 1, 0, 3, 2.
- R6: An advance from the fourth beat wraps back to beat 0. The address returns to the loaded start and never leaves its aligned 4-word group.
- R7: At a clock edge with `suspend`=0, `step`=0 and `sel`=0, any burst ends. `burst_active` becomes 0 and the beat returns to 0, so `addr_out` shows the loaded start address. While no burst is active, `step`=1 changes nothing.
- R8: At a clock edge with `suspend`=1, all other inputs are ignored and `addr_out` and `burst_active` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| suspend | input | 1 | 1 = hold all state this cycle |
| step | input | 1 | 1 = advance burst, 0 = load (or end if deselected) |
| sel | input | 1 | Select qualifier for load cycles, active high |
| order_ilv | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current beat address |
| burst_active | output | 1 | A burst is in progress |

## Verification
The assertions check these properties on every cycle:
- a load captures the external address;
- the upper address bits do not move outside a load;
- a deselected load drops the active flag;
- suspend freezes both outputs;
- an advance from the last beat lands back on the start.

Some properties are only shown by the bench scenarios. These are the exact linear and interleaved sequences for each of the four start values, a restart in the middle of a burst, and advances that arrive while no burst is active. The bench compares these against a behavioural model on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_END,
        CMD_STEP
    } burst_cmd_e;

    // Resolve the control inputs of one cycle into a single action.
    function automatic burst_cmd_e decode_cmd(
        input logic suspend,
        input logic step,
        input logic sel,
        input logic active
    );
        burst_cmd_e cmd;
        if (suspend)         cmd = CMD_IDLE;
        else if (!step)      cmd = sel ? CMD_LOAD : CMD_END;
        else if (active)     cmd = CMD_STEP;
        else                 cmd = CMD_IDLE;
        return cmd;
    endfunction

    // Low address bits for a given beat under the selected order.
    function automatic beat_t map_beat(
        input burst_order_e ord,
        input beat_t        start,
        input beat_t        beat
    );
        beat_t r;
        unique case (ord)
            ORD_INTERLEAVE: r = start ^ beat;
            default:        r = start + beat;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_load_reg.sv
module burst_load_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic              active_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            active_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    base_q   <= addr_in;
                    active_q <= 1'b1;
                end
                CMD_END:  active_q <= 1'b0;
                default:  ;
            endcase
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_LOAD |=> base_q == $past(addr_in) && active_q); // R2
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_LOAD |=> $stable(base_q)); // R3
    AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_END |=> !active_q); // R7

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  burst_cmd_e cmd,
    output beat_t      beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD, CMD_END: beat_q <= '0;
                CMD_STEP:          beat_q <= beat_q + 1'b1;
                default:           ;
            endcase
        end
    end

    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_STEP |=> beat_q == beat_t'($past(beat_q) + 1)); // R4
    AST_BEAT_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_IDLE |=> $stable(beat_q)); // R8

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  burst_order_e      order,
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0] upper;
    beat_t           start;

    assign upper = base[ADDR_W-1:BEAT_W];
    assign start = base[BEAT_W-1:0];
    assign addr  = {upper, map_beat(order, start, beat)};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              suspend,
    input  logic              step,
    input  logic              sel,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);

    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] base;
    beat_t             beat;
    burst_order_e      order;

    assign order = burst_order_e'(order_ilv);
    assign cmd   = decode_cmd(suspend, step, sel, burst_active);

    burst_load_reg #(.ADDR_W(ADDR_W)) i_load (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_in  (addr_in),
        .base_q   (base),
        .active_q (burst_active)
    );

    burst_beat_ctr i_beat (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .beat_q (beat)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) i_map (
        .order (order),
        .base  (base),
        .beat  (beat),
        .addr  (addr_out)
    );

    AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (rst)
        suspend |=> $stable(addr_out) && $stable(burst_active)); // R8
    AST_WRAP_HOME: assert property (@(posedge clk) disable iff (rst)
        (!suspend && step && burst_active && beat == beat_t'(BEATS - 1))
        |=> addr_out == base); // R6
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!suspend && step)
        |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R3

endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst, suspend, step, sel, order_ilv;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural model state
    int m_base, m_beat, m_act;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk(clk), .rst(rst), .suspend(suspend), .step(step), .sel(sel),
        .order_ilv(order_ilv), .addr_in(addr_in),
        .addr_out(addr_out), .burst_active(burst_active)
    );

    function automatic int exp_addr();
        int lo, hi;
        hi = m_base & ~3;
        lo = order_ilv ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
        return hi | lo;
    endfunction

    task automatic compare(string tag);
        n_checks++;
        if (addr_out !== AW'(exp_addr()) || burst_active !== m_act[0]) begin
            n_fail++;
            $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0b",
                     tag, addr_out, burst_active, AW'(exp_addr()), m_act[0]);
        end
    endtask

    // one clock: model follows the same inputs, compare after the edge
    task automatic cycle(string tag);
        @(posedge clk);
        if (rst) begin
            m_base = 0; m_beat = 0; m_act = 0;
        end else if (!suspend) begin
            if (!step) begin
                if (sel) begin m_base = int'(addr_in); m_beat = 0; m_act = 1; end
                else     begin m_beat = 0; m_act = 0; end
            end else if (m_act != 0) begin
                m_beat = (m_beat + 1) % 4;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drive(logic s, logic st, logic se, logic [AW-1:0] a);
        suspend = s; step = st; sel = se; addr_in = a;
    endtask

    task automatic do_reset(logic ord);
        order_ilv = ord;
        rst = 1'b1;
        drive(0, 1, 0, '0);
        cycle("R1");
        cycle("R1");
        rst = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_base = 0; m_beat = 0; m_act = 0;
        @(negedge clk);
        // R1 linear mode from reset
        do_reset(1'b0);
        drive(0, 1, 0, 20'hABCDE);
        cycle("R1");                           // advance with no burst: still reset state (R7)

        // R4 linear start 2 -> 2,3,0,1 then wrap R6
        drive(0, 0, 1, 20'h12346);  cycle("R2");
        drive(0, 1, 1, 20'hFFFFF);  cycle("R4");
        drive(0, 1, 0, 20'h00000);  cycle("R4");
        drive(0, 1, 1, 20'h55555);  cycle("R3");
        drive(0, 1, 1, 20'hAAAAA);  cycle("R6");
        drive(0, 1, 1, 20'h0);      cycle("R4");

        // R8 suspend ignores load, deselect and advance
        drive(1, 0, 1, 20'h77777);  cycle("R8");
        drive(1, 0, 0, 20'h0);      cycle("R8");
        drive(1, 1, 1, 20'h0);      cycle("R8");

        // R7 deselected load ends burst; advances then do nothing
        drive(0, 0, 0, 20'h99999);  cycle("R7");
        drive(0, 1, 1, 20'h11111);  cycle("R7");
        drive(0, 1, 1, 20'h22222);  cycle("R7");

        // linear sweep of every start with wrap
        for (int s = 0; s < 4; s++) begin
            drive(0, 0, 1, AW'(20'h3C000 + s)); cycle("R2");
            for (int b = 0; b < 5; b++) begin
                drive(0, 1, 1, AW'(b * 7)); cycle(b == 3 ? "R6" : "R4");
            end
        end

        // R5 interleaved mode
        do_reset(1'b1);
        drive(0, 0, 1, 20'h80001);  cycle("R2");
        drive(0, 1, 1, 20'h0);      cycle("R5");
        drive(0, 1, 1, 20'h0);      cycle("R5");
        drive(0, 1, 1, 20'h0);      cycle("R5");
        drive(0, 1, 1, 20'h0);      cycle("R6");
        drive(0, 1, 1, 20'h0);      cycle("R5");
        // R2 restart in the middle of a burst
        drive(0, 0, 1, 20'h4F00E);  cycle("R2");
        drive(0, 1, 1, 20'h0);      cycle("R5");
        drive(1, 1, 1, 20'h0);      cycle("R8");
        drive(0, 1, 1, 20'h0);      cycle("R5");
        drive(0, 0, 0, 20'h0);      cycle("R7");

        for (int s = 0; s < 4; s++) begin
            drive(0, 0, 1, AW'(20'hE1230 + s)); cycle("R2");
            for (int b = 0; b < 5; b++) begin
                drive(0, 1, 1, AW'(b * 13)); cycle(b == 3 ? "R6" : "R5");
            end
        end

        // R1 reset mid-burst
        rst = 1'b1; drive(0, 1, 1, '0); cycle("R1");
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule